// File: doc/BRIEF.md
# Questionable-Status Condition and Event Group

This block collects three live fault indications for a measuring instrument and reports them through a status register group. The first is an amplifier overrange on either input path, counted only while a measurement is running. The second is a sample-rate accuracy fault, found by comparing the requested sampling period of each of two timers with the period the clock divider can actually reach. The third is a calibration storage error. The three faults are sampled into a 16-bit condition word. Each bit has a rising-edge enable and a falling-edge enable, and these decide which changes are latched into a sticky event word.

Software uses a small read/write port to reach the condition word, both edge-enable words, the event word and an enable mask. A read of the event word clears it. A registered summary flag is high whenever an enabled event bit is set. A soft clear input clears the status words and leaves the configuration as it is.

Top module: `qstat_group`

## Requirements
- R1: The condition word is 16 bits wide. Only bit 0 (overrange), bit 2 (rate accuracy) and bit 8 (calibration) are implemented. All other bits of every register read 0, and a read of an unmapped address (5 to 7) returns 0.
- R2: Bit 0 of the condition word equals (ovr_se OR ovr_diff) AND meas_active, sampled on the next clock edge.
- R3: Bit 2 of the condition word is 1 when, for either timer, 100*|achieved-requested| > requested. A deviation of exactly 1% is not a fault.
- R4: Bit 8 of the condition word follows cal_err, sampled on the next clock edge.
- R5: A read of address 0 (condition) changes no register, and a write to address 0 has no effect.
- R6: rst clears the condition and event words and loads the rising-edge enables (address 1) with 16'h0105, the falling-edge enables (address 2) with 0 and the enable mask (address 4) with 0. If cal_err is still high, bit 8 of the condition word returns on the first edge after rst is released.
- R7: A condition bit that goes 0 to 1 sets its event bit when its rising-edge enable is 1. A condition bit that goes 1 to 0 sets its event bit when its falling-edge enable is 1. The event bit is set on the same edge at which the condition bit changes. A change whose enable is 0 sets nothing.
- R8: Event bits (address 3) stay set. A read of address 3 returns the word and clears it.
- R9: An event bit that is set on the same edge as an event-word read is still set after that read.
- R10: summary is a register that holds the OR over all bits of (event AND enable) as it stood one clock earlier.
- R11: soft_clr clears the condition and event words and leaves both edge-enable words and the enable mask unchanged.
- R12: The port's read data is registered and is valid on the edge that samples reg_rd. Writes to addresses 1, 2 and 4 store only bits 0, 2 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Clears the condition and event words |
| ovr_se | input | 1 | Single-ended input overrange flag |
| ovr_diff | input | 1 | Differential input overrange flag |
| meas_active | input | 1 | A measurement sequence is running |
| cal_err | input | 1 | Calibration storage error |
| req_per_a | input | PW | Requested period, timer A |
| ach_per_a | input | PW | Achievable period, timer A |
| req_per_b | input | PW | Requested period, timer B |
| ach_per_b | input | PW | Achievable period, timer B |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | 0 condition, 1 rising enable, 2 falling enable, 3 event, 4 enable mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| summary | output | 1 | Any enabled event bit is set |

## Verification
The hardest case to reach from the ports is an event bit that becomes set on the very edge at which software reads and clears the event word. The bench drives a new overrange and an event-word read in the same half cycle, so that the bit rises and the clear happens at one edge. It then checks that this read returns the old word and that the next read still shows the new bit. A second hard case is the calibration bit coming back after a reset or soft clear while cal_err stays high. The bench holds cal_err through rst and reads the condition word on the release edge and again on the edge after it.

// File: rtl/qstat_pkg.sv
`timescale 1ns/1ps
package qstat_pkg;
  localparam int CW = 16;
  localparam int B_VOLT = 0;
  localparam int B_TIME = 2;
  localparam int B_CAL  = 8;
  localparam logic [CW-1:0] USED = 16'h0105;
  localparam int AW = 3;
  localparam logic [AW-1:0] ADR_COND = 3'd0;
  localparam logic [AW-1:0] ADR_PTR  = 3'd1;
  localparam logic [AW-1:0] ADR_NTR  = 3'd2;
  localparam logic [AW-1:0] ADR_EVT  = 3'd3;
  localparam logic [AW-1:0] ADR_ENA  = 3'd4;
endpackage

// File: rtl/qstat_rate_chk.sv
`timescale 1ns/1ps
module qstat_rate_chk #(
  parameter int PW = 24
) (
  input  logic [PW-1:0] req,
  input  logic [PW-1:0] ach,
  output logic          fault
);
  localparam int XW = PW + 7;
  logic [PW-1:0] diff;
  logic [XW-1:0] scaled;
  logic [XW-1:0] limit;

  always_comb begin
    diff   = (ach >= req) ? (ach - req) : (req - ach);
    scaled = XW'(diff) * XW'(100);
    limit  = XW'(req);
    fault  = scaled > limit;
  end

  // R3: a fault needs a nonzero gap between the two periods
  always_comb begin
    if (fault) begin
      assert_fault_needs_gap_R3: assert (ach != req);
    end
  end
endmodule

// File: rtl/qstat_cond.sv
`timescale 1ns/1ps
module qstat_cond
  import qstat_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          ovr_se,
  input  logic          ovr_diff,
  input  logic          meas_active,
  input  logic          cal_err,
  input  logic          rate_fault,
  output logic [CW-1:0] cond_d,
  output logic [CW-1:0] cond_q
);
  always_comb begin
    cond_d         = '0;
    cond_d[B_VOLT] = (ovr_se | ovr_diff) & meas_active;
    cond_d[B_TIME] = rate_fault;
    cond_d[B_CAL]  = cal_err;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) cond_q <= '0;
    else                 cond_q <= cond_d;
  end

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (cond_q & ~USED) == '0);

  assert_volt_needs_meas_R2: assert property (@(posedge clk) disable iff (rst)
    cond_q[B_VOLT] |-> $past(meas_active));

  assert_cal_follows_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(cal_err) && !$past(soft_clr) && !$past(rst)) |-> cond_q[B_CAL]);
endmodule

// File: rtl/qstat_event.sv
`timescale 1ns/1ps
module qstat_event
  import qstat_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic [CW-1:0] cond_d,
  input  logic [CW-1:0] cond_q,
  input  logic [CW-1:0] ptr,
  input  logic [CW-1:0] ntr,
  input  logic [CW-1:0] en,
  input  logic          rd_clr,
  output logic [CW-1:0] evt_q,
  output logic          summary
);
  logic [CW-1:0] set;

  always_comb set = (cond_d & ~cond_q & ptr) | (~cond_d & cond_q & ntr);

  always_ff @(posedge clk) begin
    if (rst || soft_clr) evt_q <= '0;
    else if (rd_clr)     evt_q <= set;
    else                 evt_q <= evt_q | set;
  end

  always_ff @(posedge clk) begin
    if (rst) summary <= 1'b0;
    else     summary <= |(evt_q & en);
  end

  assert_no_unfiltered_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && !soft_clr) |=> ((evt_q & ~$past(evt_q) & ~$past(ptr | ntr)) == '0));

  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && !soft_clr) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  assert_keep_concurrent_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !soft_clr) |=> ((evt_q & $past(set)) == $past(set)));

  assert_summary_mask_R10: assert property (@(posedge clk) disable iff (rst)
    ((evt_q & en) == '0) |=> !summary);
endmodule

// File: rtl/qstat_group.sv
`timescale 1ns/1ps
module qstat_group
  import qstat_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          ovr_se,
  input  logic          ovr_diff,
  input  logic          meas_active,
  input  logic          cal_err,
  input  logic [PW-1:0] req_per_a,
  input  logic [PW-1:0] ach_per_a,
  input  logic [PW-1:0] req_per_b,
  input  logic [PW-1:0] ach_per_b,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          summary
);
  localparam int NT = 2;

  logic [PW-1:0] req_arr [NT];
  logic [PW-1:0] ach_arr [NT];
  logic [NT-1:0] t_fault;
  logic          rate_fault;

  always_comb begin
    req_arr[0] = req_per_a;
    ach_arr[0] = ach_per_a;
    req_arr[1] = req_per_b;
    ach_arr[1] = ach_per_b;
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    qstat_rate_chk #(.PW(PW)) u_chk (
      .req   (req_arr[t]),
      .ach   (ach_arr[t]),
      .fault (t_fault[t])
    );
  end

  assign rate_fault = |t_fault;

  logic [CW-1:0] cond_d, cond_q, evt_q;
  logic [CW-1:0] ptr_q, ntr_q, en_q;
  logic          rd_clr;

  assign rd_clr = reg_rd && (reg_addr == ADR_EVT);

  qstat_cond u_cond (
    .clk         (clk),
    .rst         (rst),
    .soft_clr    (soft_clr),
    .ovr_se      (ovr_se),
    .ovr_diff    (ovr_diff),
    .meas_active (meas_active),
    .cal_err     (cal_err),
    .rate_fault  (rate_fault),
    .cond_d      (cond_d),
    .cond_q      (cond_q)
  );

  qstat_event u_evt (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (soft_clr),
    .cond_d   (cond_d),
    .cond_q   (cond_q),
    .ptr      (ptr_q),
    .ntr      (ntr_q),
    .en       (en_q),
    .rd_clr   (rd_clr),
    .evt_q    (evt_q),
    .summary  (summary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= USED;
      ntr_q <= '0;
      en_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_PTR: ptr_q <= reg_wdata & USED;
        ADR_NTR: ntr_q <= reg_wdata & USED;
        ADR_ENA: en_q  <= reg_wdata & USED;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_COND: reg_rdata <= cond_q;
        ADR_PTR:  reg_rdata <= ptr_q;
        ADR_NTR:  reg_rdata <= ntr_q;
        ADR_EVT:  reg_rdata <= evt_q;
        ADR_ENA:  reg_rdata <= en_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assert_rdata_unused_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~USED) == '0);

  assert_cfg_kept_R11: assert property (@(posedge clk) disable iff (rst)
    (soft_clr && !reg_wr) |=> $stable(ptr_q) && $stable(ntr_q) && $stable(en_q));
endmodule

// File: tb/tb_qstat_group.sv
`timescale 1ns/1ps
module tb_qstat_group;
  localparam int PW = 24;

  logic          clk = 1'b0;
  logic          rst, soft_clr, ovr_se, ovr_diff, meas_active, cal_err;
  logic [PW-1:0] req_per_a, ach_per_a, req_per_b, ach_per_b;
  logic          reg_wr, reg_rd;
  logic [2:0]    reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;
  logic          summary;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  qstat_group #(.PW(PW)) dut (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .ovr_se(ovr_se), .ovr_diff(ovr_diff),
    .meas_active(meas_active), .cal_err(cal_err),
    .req_per_a(req_per_a), .ach_per_a(ach_per_a), .req_per_b(req_per_b), .ach_per_b(ach_per_b),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .summary(summary)
  );

  typedef struct packed {
    logic se, df, ms, cal;
    logic [PW-1:0] ra, aa, rb, ab;
    logic [15:0] ex;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0, 24'd1000,24'd1000, 24'd500,24'd500, 16'h0000},
    '{1'b1,1'b0,1'b0,1'b0, 24'd1000,24'd1000, 24'd500,24'd500, 16'h0000},
    '{1'b1,1'b0,1'b1,1'b0, 24'd1000,24'd1000, 24'd500,24'd500, 16'h0001},
    '{1'b0,1'b1,1'b1,1'b0, 24'd1000,24'd1000, 24'd500,24'd500, 16'h0001},
    '{1'b0,1'b0,1'b1,1'b0, 24'd1000,24'd1010, 24'd500,24'd505, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b0, 24'd1000,24'd1011, 24'd500,24'd500, 16'h0004},
    '{1'b0,1'b0,1'b0,1'b0, 24'd1000,24'd1000, 24'd500,24'd494, 16'h0004},
    '{1'b0,1'b0,1'b0,1'b1, 24'd1000,24'd989,  24'd500,24'd500, 16'h0104},
    '{1'b0,1'b0,1'b0,1'b0, 24'd1000,24'd990,  24'd500,24'd495, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic quiet();
    @(negedge clk);
    ovr_se = 0; ovr_diff = 0; meas_active = 0; cal_err = 0;
    req_per_a = 1000; ach_per_a = 1000; req_per_b = 500; ach_per_b = 500;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst = 1; soft_clr = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    ovr_se = 0; ovr_diff = 0; meas_active = 0; cal_err = 0;
    req_per_a = 1000; ach_per_a = 1000; req_per_b = 500; ach_per_b = 500;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R6 reset values
    rd(3'd0, d); chk("R6 cond after reset", d, 16'h0000);
    rd(3'd1, d); chk("R6 rising enable default", d, 16'h0105);
    rd(3'd2, d); chk("R6 falling enable default", d, 16'h0000);
    rd(3'd4, d); chk("R6 enable mask default", d, 16'h0000);
    rd(3'd3, d); chk("R6 event after reset", d, 16'h0000);
    chk("R10 summary after reset", {15'd0, summary}, 16'h0000);

    // R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ovr_se = VT[i].se; ovr_diff = VT[i].df; meas_active = VT[i].ms; cal_err = VT[i].cal;
      req_per_a = VT[i].ra; ach_per_a = VT[i].aa; req_per_b = VT[i].rb; ach_per_b = VT[i].ab;
      rd(3'd0, d);
      chk($sformatf("R2/R3/R4 vector %0d", i), d, VT[i].ex);
    end

    // R7 R8: every implemented bit rose with default rising enables
    rd(3'd3, d); chk("R7 events latched by rising edges", d, 16'h0105);
    rd(3'd3, d); chk("R8 event cleared by read", d, 16'h0000);

    // R1 unmapped address and masked writes
    rd(3'd6, d); chk("R1 unmapped read", d, 16'h0000);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, d); chk("R12 enable write masked", d, 16'h0105);
    wr(3'd4, 16'h0000);

    // R5 condition read and write have no effect
    @(negedge clk); ach_per_a = 1100;
    repeat (2) @(negedge clk);
    rd(3'd3, d);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); chk("R5 cond unchanged by write", d, 16'h0004);
    rd(3'd0, d); chk("R5 cond unchanged by read", d, 16'h0004);
    rd(3'd3, d); chk("R5 event untouched by cond access", d, 16'h0000);
    quiet();
    rd(3'd3, d);

    // R7 falling-edge filter
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0001);
    @(negedge clk); ovr_se = 1; meas_active = 1; ach_per_a = 1100;
    repeat (2) @(negedge clk);
    rd(3'd3, d); chk("R7 rising edge blocked", d, 16'h0000);
    @(negedge clk); ovr_se = 0; ach_per_a = 1000;
    repeat (2) @(negedge clk);
    rd(3'd3, d); chk("R7 falling edge latched", d, 16'h0001);
    quiet();
    wr(3'd1, 16'h0105);
    wr(3'd2, 16'h0000);
    rd(3'd3, d);

    // R9 event set on the same edge as the clearing read
    @(negedge clk); meas_active = 1;
    @(negedge clk);
    ovr_se = 1; reg_rd = 1; reg_addr = 3'd3;
    @(posedge clk); #1;
    chk("R9 read returns old word", reg_rdata, 16'h0000);
    @(negedge clk); reg_rd = 0;
    rd(3'd3, d); chk("R9 concurrent event kept", d, 16'h0001);
    quiet();
    rd(3'd3, d);

    // R10 summary
    wr(3'd4, 16'h0004);
    @(negedge clk); ovr_se = 1; meas_active = 1;
    repeat (3) @(negedge clk);
    chk("R10 masked event no summary", {15'd0, summary}, 16'h0000);
    @(negedge clk); ach_per_b = 600;
    repeat (3) @(negedge clk);
    chk("R10 enabled event raises summary", {15'd0, summary}, 16'h0001);
    rd(3'd3, d); chk("R10 event word", d, 16'h0005);
    repeat (2) @(negedge clk);
    chk("R10 summary drops after clear", {15'd0, summary}, 16'h0000);
    quiet();

    // R11 soft clear
    wr(3'd4, 16'h0001);
    @(negedge clk); ovr_se = 1; meas_active = 1;
    repeat (2) @(negedge clk);
    @(negedge clk); ovr_se = 0;
    repeat (2) @(negedge clk);
    @(negedge clk); soft_clr = 1;
    @(negedge clk); soft_clr = 0;
    repeat (2) @(negedge clk);
    rd(3'd3, d); chk("R11 event cleared by soft clear", d, 16'h0000);
    rd(3'd4, d); chk("R11 enable kept", d, 16'h0001);
    rd(3'd1, d); chk("R11 rising enable kept", d, 16'h0105);
    chk("R11 summary low", {15'd0, summary}, 16'h0000);

    // R6 R4 calibration bit returns after reset
    @(negedge clk); cal_err = 1;
    repeat (2) @(negedge clk);
    wr(3'd2, 16'h0004);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; reg_rd = 1; reg_addr = 3'd0;
    @(posedge clk); #1;
    chk("R6 cond cleared at reset", reg_rdata, 16'h0000);
    @(negedge clk); reg_rd = 0;
    rd(3'd0, d); chk("R6 cal bit returns", d, 16'h0100);
    rd(3'd2, d); chk("R6 falling enable reset", d, 16'h0000);
    rd(3'd3, d); chk("R6 cal return latched as event", d, 16'h0100);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule